// File: doc/BRIEF.md
# Threshold-Gated Pending Interrupt Selector

This block sits between the interrupt sources and a processor core. It keeps a request register with one bit for every interrupt vector number. A request strobe carries an 8-bit vector and sets that vector's bit. A second request for a vector that is already waiting does not queue a second copy: it merges into the bit that is already set.

Software writes a 4-bit threshold. The upper four bits of a vector number form its priority class. A waiting vector is offered to the core only when its class is strictly above the threshold. Among the vectors that qualify, the one with the largest number is offered.

The core takes the offered vector with a one-cycle acknowledge, and that clears the vector's bit. A vector held back by the threshold stays in the register for as long as it takes, and it is offered once the threshold drops below its class.

Top module: `irq_accept_unit`

## Requirements
- R1: After a synchronous active-high reset the request register is empty, the threshold is 0 and `irq_pending` is low.
- R2: A cycle with `req_valid` high sets the bit of the vector on `req_vec` (an 8-bit vector number, 0 to 255) at the next clock edge.
- R3: A request for a vector whose bit is already set merges with it, so a single acknowledge of that vector leaves no copy behind.
- R4: The class of a vector is `req_vec[7:4]`. A waiting vector qualifies only when its class is strictly greater than the threshold.
- R5: With threshold 15 nothing is offered. With threshold 0 every waiting vector of class 1 or more is offered. Class 0 vectors are never offered.
- R6: A vector blocked by the threshold is never dropped, however long it waits. It is offered as soon as the threshold falls below its class.
- R7: When several waiting vectors qualify, `irq_vec` shows the one with the highest vector number.
- R8: `irq_pending` follows the stored state combinationally. It is high exactly when at least one waiting vector qualifies, and `irq_vec` is valid while it is high.
- R9: `ack` high while `irq_pending` is high clears the bit of the vector then shown on `irq_vec`, at the next edge. `ack` while `irq_pending` is low changes nothing.
- R10: If a request for the shown vector arrives in the same cycle as its acknowledge, the bit stays set.
- R11: A threshold write (`thr_we` with `thr_data`) takes effect at the next clock edge. Before that edge the old threshold still governs the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_vec | input | 8 | Vector number of the request |
| thr_we | input | 1 | Threshold write enable |
| thr_data | input | 4 | New threshold value |
| ack | input | 1 | Core accepts the offered vector |
| irq_pending | output | 1 | A qualifying vector is waiting |
| irq_vec | output | 8 | Highest qualifying vector number |

## Verification
Each of the 256 vectors is posted alone and viewed under all 16 thresholds. This separates a strict class comparison from a greater-or-equal one and from a comparison on the wrong nibble. A long wait at threshold 15 followed by a drop to 0 shows whether blocked vectors survive.

Pseudo-random mixes of several vectors, with duplicate posts and interleaved acknowledges, are compared against an arithmetic model. These runs expose a wrong winner, lost merges and clears that hit the wrong bit. Directed cycles cover the following cases:
- an acknowledge that coincides with a new request for the same vector;
- an acknowledge while nothing qualifies;
- the edge at which a threshold write becomes active.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DEF_VEC_W = 8;
  localparam int DEF_THR_W = 4;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NUM   = 256,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [NUM-1:0]   bits
);
  for (genvar i = 0; i < NUM; i++) begin : g_bit
    logic hit_set, hit_clr;
    assign hit_set = set_en && (set_idx == IDX_W'(i));
    assign hit_clr = clr_en && (clr_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (rst) bits[i] <= 1'b0;
      else     bits[i] <= (bits[i] && !hit_clr) || hit_set;
    end
  end
endmodule

// File: rtl/irq_class_gate.sv
module irq_class_gate #(
  parameter int NUM   = 256,
  parameter int IDX_W = 8,
  parameter int THR_W = 4
) (
  input  logic [NUM-1:0]   bits,
  input  logic [THR_W-1:0] thr,
  output logic [NUM-1:0]   eligible
);
  localparam int SHIFT = IDX_W - THR_W;
  for (genvar i = 0; i < NUM; i++) begin : g_gate
    localparam int CLS = i >> SHIFT;
    assign eligible[i] = bits[i] && (THR_W'(CLS) > thr);
  end
endmodule

// File: rtl/irq_top_pick.sv
module irq_top_pick #(
  parameter int NUM   = 256,
  parameter int IDX_W = 8
) (
  input  logic [NUM-1:0]   eligible,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < NUM; i++) begin
      if (eligible[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit #(
  parameter int VEC_W = irq_pkg::DEF_VEC_W,
  parameter int THR_W = irq_pkg::DEF_THR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VEC_W-1:0] req_vec,
  input  logic             thr_we,
  input  logic [THR_W-1:0] thr_data,
  input  logic             ack,
  output logic             irq_pending,
  output logic [VEC_W-1:0] irq_vec
);
  localparam int NUM_VEC = 1 << VEC_W;

  logic [NUM_VEC-1:0] pend_bits;
  logic [NUM_VEC-1:0] eligible;
  logic [THR_W-1:0]   thr_q;
  logic               take;

  assign take = ack && irq_pending;

  always_ff @(posedge clk) begin
    if (rst)         thr_q <= '0;
    else if (thr_we) thr_q <= thr_data;
  end

  irq_pend_bank #(.NUM(NUM_VEC), .IDX_W(VEC_W)) u_bank (
    .clk(clk), .rst(rst),
    .set_en(req_valid), .set_idx(req_vec),
    .clr_en(take), .clr_idx(irq_vec),
    .bits(pend_bits)
  );

  irq_class_gate #(.NUM(NUM_VEC), .IDX_W(VEC_W), .THR_W(THR_W)) u_gate (
    .bits(pend_bits), .thr(thr_q), .eligible(eligible)
  );

  irq_top_pick #(.NUM(NUM_VEC), .IDX_W(VEC_W)) u_pick (
    .eligible(eligible), .any(irq_pending), .idx(irq_vec)
  );

  AST_REQ_LANDS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> pend_bits[$past(req_vec)]); // R2
  AST_CLASS_ABOVE: assert property (@(posedge clk) disable iff (rst)
    irq_pending |-> (irq_vec[VEC_W-1 -: THR_W] > thr_q)); // R4
  AST_TOP_WINS: assert property (@(posedge clk) disable iff (rst)
    irq_pending |-> ((eligible >> irq_vec) == NUM_VEC'(1))); // R7
  AST_NO_DISCARD: assert property (@(posedge clk) disable iff (rst)
    !ack |=> ($countones(pend_bits) >= $past($countones(pend_bits)))); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (take && !(req_valid && req_vec == irq_vec)) |=> !pend_bits[$past(irq_vec)]); // R9
  AST_ACK_COLLIDE: assert property (@(posedge clk) disable iff (rst)
    (take && req_valid && req_vec == irq_vec) |=> pend_bits[$past(irq_vec)]); // R10
  AST_THR_LOAD: assert property (@(posedge clk) disable iff (rst)
    thr_we |=> (thr_q == $past(thr_data))); // R11
endmodule

// File: tb/irq_accept_unit_test.sv
module irq_accept_unit_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b0;
  logic       req_valid = 1'b0;
  logic [7:0] req_vec = '0;
  logic       thr_we = 1'b0;
  logic [3:0] thr_data = '0;
  logic       ack = 1'b0;
  logic       irq_pending;
  logic [7:0] irq_vec;

  logic [255:0] m_pend;
  logic [3:0]   m_thr;
  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_accept_unit uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vec(req_vec),
    .thr_we(thr_we), .thr_data(thr_data), .ack(ack),
    .irq_pending(irq_pending), .irq_vec(irq_vec)
  );

  function automatic logic [8:0] expect_out(input logic [255:0] p, input logic [3:0] t);
    for (int i = 255; i >= 0; i--)
      if (p[i] && ((i / 16) > int'(t))) return {1'b1, 8'(i)};
    return 9'd0;
  endfunction

  task automatic chk(input string tag);
    logic [8:0] e;
    e = expect_out(m_pend, m_thr);
    n_chk++;
    if (irq_pending !== e[8] || (e[8] && irq_vec !== e[7:0])) begin
      n_fail++;
      $display("FAIL %s: pending=%0b vec=%0d expected pending=%0b vec=%0d",
               tag, irq_pending, irq_vec, e[8], e[7:0]);
    end
  endtask

  task automatic cyc(input logic rv, input logic [7:0] rvec,
                     input logic tw, input logic [3:0] td, input logic a);
    logic [8:0] e;
    @(negedge clk);
    req_valid = rv; req_vec = rvec; thr_we = tw; thr_data = td; ack = a;
    e = expect_out(m_pend, m_thr);
    if (a && e[8]) m_pend[e[7:0]] = 1'b0;
    if (rv) m_pend[rvec] = 1'b1;
    if (tw) m_thr = td;
    @(posedge clk);
    #1;
    req_valid = 1'b0; thr_we = 1'b0; ack = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1;
    rst = 1'b0;
    m_pend = '0;
    m_thr = '0;
  endtask

  function automatic logic [15:0] step_lfsr(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 reset");
    cyc(1'b1, 8'h10, 1'b0, 4'd0, 1'b0);
    chk("R1 threshold zero after reset");
    cyc(1'b0, 8'h00, 1'b0, 4'd0, 1'b1);
    chk("R9 ack clears");

    // Single vector, every threshold
    for (int v = 0; v < 256; v++) begin
      do_reset();
      cyc(1'b1, 8'(v), 1'b0, 4'd0, 1'b0);
      chk("R2 R8 post");
      for (int t = 1; t < 16; t++) begin
        cyc(1'b0, 8'h00, 1'b1, 4'(t), 1'b0);
        chk((t == 15) ? "R5 block all" : "R4 class gate");
      end
      repeat (20) cyc(1'b0, 8'h00, 1'b0, 4'd0, 1'b0);
      cyc(1'b0, 8'h00, 1'b1, 4'd0, 1'b0);
      chk("R6 R5 released");
      cyc(1'b0, 8'h00, 1'b0, 4'd0, 1'b1);
      chk("R9 cleared");
    end

    // Merge
    do_reset();
    cyc(1'b1, 8'hA0, 1'b0, 4'd0, 1'b0);
    cyc(1'b1, 8'hA0, 1'b0, 4'd0, 1'b0);
    chk("R3 merged post");
    cyc(1'b0, 8'h00, 1'b0, 4'd0, 1'b1);
    chk("R3 single ack empties");

    // Ack colliding with a new request
    do_reset();
    cyc(1'b1, 8'h80, 1'b0, 4'd0, 1'b0);
    cyc(1'b1, 8'h80, 1'b0, 4'd0, 1'b1);
    chk("R10 kept");
    cyc(1'b0, 8'h00, 1'b0, 4'd0, 1'b1);
    chk("R10 then cleared");

    // Ack with nothing qualifying
    do_reset();
    cyc(1'b1, 8'h35, 1'b1, 4'd5, 1'b0);
    chk("R9 blocked");
    cyc(1'b0, 8'h00, 1'b0, 4'd0, 1'b1);
    cyc(1'b0, 8'h00, 1'b1, 4'd0, 1'b0);
    chk("R9 idle ack had no effect");

    // Threshold write timing
    do_reset();
    cyc(1'b1, 8'h50, 1'b0, 4'd0, 1'b0);
    @(negedge clk);
    thr_we = 1'b1; thr_data = 4'd9;
    #1;
    chk("R11 old threshold before edge");
    @(posedge clk);
    #1;
    thr_we = 1'b0;
    m_thr = 4'd9;
    chk("R11 new threshold after edge");

    // Mixed traffic against the model
    do_reset();
    for (int r = 0; r < 400; r++) begin
      lfsr = step_lfsr(lfsr);
      cyc(1'b1, lfsr[7:0], lfsr[15:14] == 2'b00, lfsr[11:8], lfsr[13:12] == 2'b11);
      chk("R7 highest wins");
      if (lfsr[3]) begin
        cyc(1'b1, lfsr[15:8] ^ lfsr[7:0], 1'b0, 4'd0, 1'b0);
        chk("R7 R3 mix");
      end
    end
    for (int r = 0; r < 300; r++) begin
      cyc(1'b0, 8'h00, 1'b0, 4'd0, 1'b1);
      chk("R7 drain order");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule